// File: doc/BRIEF.md
# Cartridge Bank Controller with Latched Real-Time Clock

This block sits between a CPU bus and the memories of a cartridge. It decodes writes in the lower half of the address space into control settings: a RAM enable, a 7-bit ROM bank, and a selector for the external-RAM window. It turns each bus address into a physical ROM or RAM address, and it returns read data for the CPU from ROM, RAM or its own clock registers.

The clock keeps seconds, minutes, hours and a 9-bit day count. It advances on a one-cycle `tick1Hz` strobe. A control byte holds day bit 8, a halt bit and a sticky day-overflow flag. Software can freeze a snapshot of all five registers with a latch command, so that several reads see one coherent time while the live clock keeps running. The RAM window at 0xA000-0xBFFF shows either the selected RAM bank or the selected clock register.

Top module: `cart_mapper_top`

## Requirements
- R1: A bus write in 0x0000-0x1FFF enables RAM when the data is 0x0A and disables it for any other value. While RAM is disabled, reads of 0xA000-0xBFFF in RAM mode return 0xFF and `ramWe` stays low.
- R2: A bus write in 0x2000-0x3FFF sets the ROM bank to data bits 6:0. A written value of 0 becomes bank 1.
- R3: A bus write in 0x4000-0x5FFF with data 0x08 to 0x0C puts the window in clock mode and selects clock register (data - 0x08). Registers are indexed 0 seconds, 1 minutes, 2 hours, 3 day bits 7:0, 4 control. Any other value leaves clock mode and sets the RAM bank to data bits 1:0.
- R4: In clock mode, a bus write in 0xA000-0xBFFF loads the data into the selected live register and never raises `ramWe`.
- R5: A bus write in 0x6000-0x7FFF with data bit 0 set copies all five live registers into the snapshot and sets the latched state. With bit 0 clear it only clears the latched state.
- R6: In clock mode, a window read returns the snapshot register while latched and the live register otherwise. Live writes made while latched do not change what is read.
- R7: Each tick advances the seconds. A field holding its last value (59 for seconds and minutes, 23 for hours) rolls to zero and carries into the next field. The day count is 9 bits, with bit 8 in control bit 0.
- R8: A carry out of day 511 wraps the day count to 0 and sets control bit 7. That bit stays set through further ticks until software writes the control register.
- R9: While control bit 6 (halt) is set, ticks do not change any clock register.
- R10: Reads of 0x0000-0x3FFF map to bank 0. Reads of 0x4000-0x7FFF map to bank x 0x4000 plus the offset. A bank number at or above `ROM_BANKS` reads as 0x00.
- R11: After reset the ROM bank is 1, the RAM bank is 0, RAM is disabled, the window is in RAM mode, all clock registers are zero and the latched state is clear.
- R12: A clock register write in the same cycle as a tick takes priority, and that tick is dropped.
- R13: In RAM mode with RAM enabled, a window write raises `ramWe`. The RAM address is the RAM bank x 0x2000 plus address bits 12:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | CPU bus address |
| busWr | input | 1 | CPU write strobe, one cycle per write |
| busWrData | input | 8 | CPU write data |
| tick1Hz | input | 1 | One-cycle clock advance strobe |
| romData | input | 8 | Byte from ROM at `romAddr` |
| ramData | input | 8 | Byte from RAM at `ramAddr` |
| romAddr | output | log2(ROM_BANKS)+14 | Physical ROM address |
| ramAddr | output | 15 | Physical RAM address |
| ramWe | output | 1 | RAM write enable |
| rdData | output | 8 | Read data returned to the CPU |

## Verification
The bench builds the block with `ROM_BANKS` = 64, which is half of what the 7-bit bank field can name. Bank writes of 0x40 and above therefore reach the zero-read path for banks past the end of ROM, which a 128-bank build could never reach. The bench models ROM and RAM so that each byte encodes its own bank and offset. Every read then shows which bank the address mapping picked.

// File: rtl/cart_mapper_pkg.sv
`timescale 1ns/1ps
package cart_mapper_pkg;
  localparam int ROM_OFS_W = 14;
  localparam int RAM_OFS_W = 13;
  localparam int ROM_SEL_W = 7;
  localparam int RAM_SEL_W = 2;
  localparam int CLK_REGS  = 5;
  localparam int CLK_IDX_W = 3;
  localparam int BYTE_W    = 8;
  localparam int RAM_AW    = RAM_SEL_W + RAM_OFS_W;

  // control-to-datapath strobes for the clock registers
  typedef struct packed {
    logic                 clkWr;
    logic [CLK_IDX_W-1:0] clkSel;
    logic                 latchSet;
    logic                 latchClr;
    logic [BYTE_W-1:0]    wrData;
  } clkStrobe_t;
endpackage

// File: rtl/cart_mapper_ctrl.sv
`timescale 1ns/1ps
module cart_mapper_ctrl
  import cart_mapper_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [15:0]          busAddr,
  input  logic [BYTE_W-1:0]    busWrData,
  output clkStrobe_t           strobe,
  output logic [ROM_SEL_W-1:0] romBankQ,
  output logic [RAM_SEL_W-1:0] ramBankQ,
  output logic                 ramEnQ,
  output logic                 clkModeQ,
  output logic [CLK_IDX_W-1:0] clkIdxQ
);
  localparam logic [BYTE_W-1:0] ENABLE_KEY = 8'h0A;
  localparam logic [BYTE_W-1:0] CLK_FIRST  = 8'h08;
  localparam logic [BYTE_W-1:0] CLK_LAST   = 8'h0C;

  logic [2:0]        region;
  logic [BYTE_W-1:0] selOff;
  logic              isClkSel;

  assign region   = busAddr[15:13];
  assign selOff   = busWrData - CLK_FIRST;
  assign isClkSel = (busWrData >= CLK_FIRST) && (busWrData <= CLK_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBankQ <= ROM_SEL_W'(1);
      ramBankQ <= '0;
      ramEnQ   <= 1'b0;
      clkModeQ <= 1'b0;
      clkIdxQ  <= '0;
    end else if (busWr) begin
      case (region)
        3'd0: ramEnQ <= (busWrData == ENABLE_KEY);
        3'd1: romBankQ <= (busWrData[ROM_SEL_W-1:0] == '0) ? ROM_SEL_W'(1)
                                                           : busWrData[ROM_SEL_W-1:0];
        3'd2: begin
          if (isClkSel) begin
            clkModeQ <= 1'b1;
            clkIdxQ  <= selOff[CLK_IDX_W-1:0];
          end else begin
            clkModeQ <= 1'b0;
            ramBankQ <= busWrData[RAM_SEL_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.clkWr    = busWr && (region == 3'd5) && clkModeQ;
    strobe.clkSel   = clkIdxQ;
    strobe.latchSet = busWr && (region == 3'd3) && busWrData[0];
    strobe.latchClr = busWr && (region == 3'd3) && !busWrData[0];
    strobe.wrData   = busWrData;
  end
endmodule

// File: rtl/cart_mapper_rtc.sv
`timescale 1ns/1ps
module cart_mapper_rtc
  import cart_mapper_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick1Hz,
  input  clkStrobe_t           strobe,
  input  logic [CLK_IDX_W-1:0] rdSel,
  output logic [BYTE_W-1:0]    rdByte,
  output logic                 latchedQ,
  output logic                 ovfQ
);
  localparam logic [BYTE_W-1:0] SEC_LAST  = 8'd59;
  localparam logic [BYTE_W-1:0] MIN_LAST  = 8'd59;
  localparam logic [BYTE_W-1:0] HOUR_LAST = 8'd23;
  localparam int DAY_W = BYTE_W + 1;

  logic [BYTE_W-1:0] secQ, minQ, hourQ, dayLoQ;
  logic              day8Q, haltQ;
  logic [BYTE_W-1:0] liveByte  [CLK_REGS];
  logic [BYTE_W-1:0] latchByte [CLK_REGS];
  logic [DAY_W-1:0]  dayCnt, dayNext;
  logic secRoll, minRoll, hourRoll, dayRoll, advance;

  assign dayCnt   = {day8Q, dayLoQ};
  assign dayNext  = dayCnt + DAY_W'(1);
  assign secRoll  = secQ  >= SEC_LAST;
  assign minRoll  = minQ  >= MIN_LAST;
  assign hourRoll = hourQ >= HOUR_LAST;
  assign dayRoll  = dayCnt == {DAY_W{1'b1}};
  assign advance  = tick1Hz && !haltQ && !strobe.clkWr;

  always_comb begin
    liveByte[0] = secQ;
    liveByte[1] = minQ;
    liveByte[2] = hourQ;
    liveByte[3] = dayLoQ;
    liveByte[4] = {ovfQ, haltQ, 5'b0, day8Q};
  end

  always_comb begin
    rdByte = '0;
    for (int i = 0; i < CLK_REGS; i++)
      if (rdSel == CLK_IDX_W'(i))
        rdByte = latchedQ ? latchByte[i] : liveByte[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= '0; minQ <= '0; hourQ <= '0; dayLoQ <= '0;
      day8Q <= 1'b0; haltQ <= 1'b0; ovfQ <= 1'b0;
    end else if (strobe.clkWr) begin
      case (strobe.clkSel)
        3'd0: secQ   <= strobe.wrData;
        3'd1: minQ   <= strobe.wrData;
        3'd2: hourQ  <= strobe.wrData;
        3'd3: dayLoQ <= strobe.wrData;
        3'd4: begin
          day8Q <= strobe.wrData[0];
          haltQ <= strobe.wrData[6];
          ovfQ  <= strobe.wrData[7];
        end
        default: ;
      endcase
    end else if (advance) begin
      secQ <= secRoll ? '0 : secQ + 8'd1;
      if (secRoll) begin
        minQ <= minRoll ? '0 : minQ + 8'd1;
        if (minRoll) begin
          hourQ <= hourRoll ? '0 : hourQ + 8'd1;
          if (hourRoll) begin
            {day8Q, dayLoQ} <= dayNext;
            if (dayRoll) ovfQ <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchedQ <= 1'b0;
      for (int i = 0; i < CLK_REGS; i++) latchByte[i] <= '0;
    end else if (strobe.latchSet) begin
      latchedQ <= 1'b1;
      for (int i = 0; i < CLK_REGS; i++) latchByte[i] <= liveByte[i];
    end else if (strobe.latchClr) begin
      latchedQ <= 1'b0;
    end
  end
endmodule

// File: rtl/cart_mapper_xlat.sv
`timescale 1ns/1ps
module cart_mapper_xlat
  import cart_mapper_pkg::*;
#(
  parameter int ROM_BANKS = 128,
  localparam int ROM_AW   = $clog2(ROM_BANKS) + ROM_OFS_W
) (
  input  logic [15:0]          busAddr,
  input  logic                 busWr,
  input  logic [ROM_SEL_W-1:0] romBankQ,
  input  logic [RAM_SEL_W-1:0] ramBankQ,
  input  logic                 ramEnQ,
  input  logic                 clkModeQ,
  input  logic [BYTE_W-1:0]    clkByte,
  input  logic [BYTE_W-1:0]    romData,
  input  logic [BYTE_W-1:0]    ramData,
  output logic [ROM_AW-1:0]    romAddr,
  output logic [RAM_AW-1:0]    ramAddr,
  output logic                 ramWe,
  output logic [BYTE_W-1:0]    rdData
);
  localparam int FULL_W = ROM_SEL_W + ROM_OFS_W;

  logic [ROM_SEL_W-1:0] bankEff;
  logic [FULL_W-1:0]    romFull;
  logic                 inWindow, bankOob;

  assign bankEff  = busAddr[14] ? romBankQ : '0;
  assign romFull  = {bankEff, busAddr[ROM_OFS_W-1:0]};
  assign romAddr  = romFull[ROM_AW-1:0];
  assign ramAddr  = {ramBankQ, busAddr[RAM_OFS_W-1:0]};
  assign inWindow = busAddr[15:13] == 3'b101;
  assign bankOob  = int'(bankEff) >= ROM_BANKS;
  assign ramWe    = busWr && inWindow && ramEnQ && !clkModeQ;

  always_comb begin
    if (!busAddr[15])    rdData = bankOob ? '0 : romData;
    else if (inWindow)   rdData = clkModeQ ? clkByte : (ramEnQ ? ramData : 8'hFF);
    else                 rdData = 8'hFF;
  end
endmodule

// File: rtl/cart_mapper_top.sv
`timescale 1ns/1ps
module cart_mapper_top
  import cart_mapper_pkg::*;
#(
  parameter int ROM_BANKS = 128,
  localparam int ROM_AW   = $clog2(ROM_BANKS) + ROM_OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  input  logic              tick1Hz,
  input  logic [7:0]        romData,
  input  logic [7:0]        ramData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [14:0]       ramAddr,
  output logic              ramWe,
  output logic [7:0]        rdData
);
  clkStrobe_t           strobe;
  logic [ROM_SEL_W-1:0] romBankQ;
  logic [RAM_SEL_W-1:0] ramBankQ;
  logic                 ramEnQ, clkModeQ, latchedQ, ovfQ;
  logic [CLK_IDX_W-1:0] clkIdxQ;
  logic [BYTE_W-1:0]    clkByte;

  cart_mapper_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .strobe(strobe), .romBankQ(romBankQ),
    .ramBankQ(ramBankQ), .ramEnQ(ramEnQ), .clkModeQ(clkModeQ), .clkIdxQ(clkIdxQ)
  );

  cart_mapper_rtc uRtc (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .strobe(strobe),
    .rdSel(clkIdxQ), .rdByte(clkByte), .latchedQ(latchedQ), .ovfQ(ovfQ)
  );

  cart_mapper_xlat #(.ROM_BANKS(ROM_BANKS)) uXlat (
    .busAddr(busAddr), .busWr(busWr), .romBankQ(romBankQ), .ramBankQ(ramBankQ),
    .ramEnQ(ramEnQ), .clkModeQ(clkModeQ), .clkByte(clkByte), .romData(romData),
    .ramData(ramData), .romAddr(romAddr), .ramAddr(ramAddr), .ramWe(ramWe),
    .rdData(rdData)
  );
endmodule

// File: rtl/cart_mapper_chk.sv
`timescale 1ns/1ps
module cart_mapper_chk
  import cart_mapper_pkg::*;
#(
  parameter int ROM_BANKS = 128
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [15:0]          busAddr,
  input logic                 busWr,
  input logic [7:0]           busWrData,
  input logic                 ramWe,
  input logic [7:0]           rdData,
  input logic [ROM_SEL_W-1:0] romBankQ,
  input logic                 clkModeQ,
  input logic                 latchedQ,
  input logic                 ovfQ,
  input clkStrobe_t           strobe
);
  p_ram_locked_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[15:13] == 3'd0 && busWrData != 8'h0A) |=> !ramWe);

  p_bank_nonzero_r2: assert property (@(posedge clk) disable iff (!rstN)
    romBankQ != '0);

  p_clock_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[15:13] == 3'd2 && busWrData >= 8'h08 && busWrData <= 8'h0C)
      |=> clkModeQ);

  p_clock_no_ram_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clkWr |-> !ramWe);

  p_latch_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchSet |=> latchedQ);

  p_latch_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchClr |=> !latchedQ);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !(strobe.clkWr && strobe.clkSel == 3'd4)) |=> ovfQ);

  p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[15:14] == 2'b01 && int'(romBankQ) >= ROM_BANKS) |-> rdData == 8'h00);
endmodule

bind cart_mapper_top cart_mapper_chk #(.ROM_BANKS(ROM_BANKS)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
  .ramWe(ramWe), .rdData(rdData), .romBankQ(romBankQ), .clkModeQ(clkModeQ),
  .latchedQ(latchedQ), .ovfQ(ovfQ), .strobe(strobe)
);

// File: tb/tb_cart_mapper_top.sv
`timescale 1ns/1ps
module tb_cart_mapper_top;
  localparam int ROM_BANKS = 64;
  localparam int ROM_AW    = $clog2(ROM_BANKS) + 14;
  localparam int NVEC      = 26;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [15:0]       busAddr = '0;
  logic              busWr = 1'b0;
  logic [7:0]        busWrData = '0;
  logic              tick1Hz = 1'b0;
  logic [7:0]        romData, ramData, rdData;
  logic [ROM_AW-1:0] romAddr;
  logic [14:0]       ramAddr;
  logic              ramWe;
  logic              lastWe;
  logic [14:0]       lastRamAddr;
  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  // memory models: each byte tells which bank and offset it came from
  assign romData = {2'b10, romAddr[ROM_AW-1:14]};
  assign ramData = {ramAddr[14:13], ramAddr[5:0]};

  cart_mapper_top #(.ROM_BANKS(ROM_BANKS)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .tick1Hz(tick1Hz), .romData(romData),
    .ramData(ramData), .romAddr(romAddr), .ramAddr(ramAddr), .ramWe(ramWe),
    .rdData(rdData)
  );

  // {write, requirement number, address, data, expected read}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 4'd11, 16'h4000, 8'h00, 8'h81},  // R11 bank 1 after reset
    {1'b1, 4'd2,  16'h2000, 8'h00, 8'h00},  // R2 write zero
    {1'b0, 4'd2,  16'h4123, 8'h00, 8'h81},
    {1'b1, 4'd10, 16'h2000, 8'h25, 8'h00},  // R10 bank 0x25
    {1'b0, 4'd10, 16'h4000, 8'h00, 8'hA5},
    {1'b1, 4'd2,  16'h2000, 8'hC3, 8'h00},  // R2 bit 7 dropped -> 0x43
    {1'b0, 4'd10, 16'h4000, 8'h00, 8'h00},  // R10 beyond 64 banks
    {1'b1, 4'd10, 16'h2000, 8'h3F, 8'h00},
    {1'b0, 4'd10, 16'h7FFF, 8'h00, 8'hBF},
    {1'b0, 4'd10, 16'h0100, 8'h00, 8'h80},  // fixed bank 0
    {1'b0, 4'd1,  16'hA005, 8'h00, 8'hFF},  // R1 disabled
    {1'b1, 4'd1,  16'h0000, 8'h0B, 8'h00},
    {1'b0, 4'd1,  16'hA005, 8'h00, 8'hFF},
    {1'b1, 4'd1,  16'h0000, 8'h0A, 8'h00},
    {1'b0, 4'd13, 16'hA005, 8'h00, 8'h05},  // R13 RAM bank 0
    {1'b1, 4'd3,  16'h4000, 8'h06, 8'h00},  // R3 bank = 2
    {1'b0, 4'd3,  16'hA005, 8'h00, 8'h85},
    {1'b1, 4'd3,  16'h4000, 8'h08, 8'h00},  // seconds
    {1'b0, 4'd11, 16'hA000, 8'h00, 8'h00},
    {1'b1, 4'd4,  16'hA000, 8'h2A, 8'h00},  // R4 load seconds
    {1'b0, 4'd4,  16'hA000, 8'h00, 8'h2A},
    {1'b1, 4'd3,  16'h4000, 8'h0B, 8'h00},  // day low
    {1'b1, 4'd4,  16'hA000, 8'h77, 8'h00},
    {1'b0, 4'd4,  16'hA1FF, 8'h00, 8'h77},
    {1'b1, 4'd3,  16'h4000, 8'h01, 8'h00},  // back to RAM bank 1
    {1'b0, 4'd3,  16'hA005, 8'h00, 8'h45}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    #1;
    lastWe = ramWe; lastRamAddr = ramAddr;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick1Hz = 1'b1;
      @(negedge clk); tick1Hz = 1'b0;
    end
  endtask

  task automatic selReg(input logic [2:0] idx);
    wr(16'h4000, 8'h08 + {5'b0, idx});
  endtask

  task automatic setReg(input logic [2:0] idx, input logic [7:0] v);
    selReg(idx);
    wr(16'hA000, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][36]) wr(VEC[i][31:16], VEC[i][15:8]);
      else rdChk(VEC[i][31:16], VEC[i][7:0], $sformatf("R%0d vec%0d", VEC[i][35:32], i));
    end

    // R13 RAM write strobe and address (bank 1, enabled)
    wr(16'hA123, 8'h55);
    check("R13 we", {7'b0, lastWe}, 8'h01);
    check("R13 addr hi", {1'b0, lastRamAddr[14:8]}, 8'h21);
    check("R13 addr lo", lastRamAddr[7:0], 8'h23);
    // R1 disabled blocks write
    wr(16'h0000, 8'h00);
    wr(16'hA123, 8'h55);
    check("R1 we", {7'b0, lastWe}, 8'h00);
    wr(16'h0000, 8'h0A);
    // R4 clock write with RAM enabled leaves RAM alone
    setReg(3'd0, 8'h11);
    check("R4 we", {7'b0, lastWe}, 8'h00);
    rdChk(16'hA000, 8'h11, "R4");

    // R7 R8 full carry chain into day overflow
    setReg(3'd0, 8'd58); setReg(3'd1, 8'd59); setReg(3'd2, 8'd23);
    setReg(3'd3, 8'hFF); setReg(3'd4, 8'h01);
    selReg(3'd0);
    tick(1); rdChk(16'hA000, 8'd59, "R7 sec");
    tick(1); rdChk(16'hA000, 8'd0, "R7 sec roll");
    selReg(3'd1); rdChk(16'hA000, 8'd0, "R7 min roll");
    selReg(3'd2); rdChk(16'hA000, 8'd0, "R7 hour roll");
    selReg(3'd3); rdChk(16'hA000, 8'd0, "R8 day wrap");
    selReg(3'd4); rdChk(16'hA000, 8'h80, "R8 overflow");
    tick(3); rdChk(16'hA000, 8'h80, "R8 sticky");
    selReg(3'd0); rdChk(16'hA000, 8'd3, "R7 count");
    setReg(3'd0, 8'd59); setReg(3'd1, 8'd10);
    tick(1); rdChk(16'hA000, 8'd11, "R7 min carry");
    selReg(3'd2); rdChk(16'hA000, 8'd0, "R7 hour held");
    setReg(3'd4, 8'h00); rdChk(16'hA000, 8'h00, "R8 cleared");

    // R9 halt
    setReg(3'd0, 8'd5); setReg(3'd4, 8'h40);
    tick(4);
    rdChk(16'hA000, 8'h40, "R9 ctrl");
    selReg(3'd0); rdChk(16'hA000, 8'd5, "R9 halted");
    setReg(3'd4, 8'h00); selReg(3'd0);
    tick(2); rdChk(16'hA000, 8'd7, "R9 resumed");

    // R12 write beats tick in the same cycle
    @(negedge clk);
    busAddr = 16'hA000; busWrData = 8'h20; busWr = 1'b1; tick1Hz = 1'b1;
    @(negedge clk);
    busWr = 1'b0; tick1Hz = 1'b0;
    rdChk(16'hA000, 8'h20, "R12");

    // R5 R6 latch
    setReg(3'd0, 8'd10);
    wr(16'h6000, 8'h01);
    tick(5);
    rdChk(16'hA000, 8'd10, "R6 latched");
    wr(16'hA000, 8'd40);
    rdChk(16'hA000, 8'd10, "R6 live write hidden");
    wr(16'h6000, 8'h00);
    rdChk(16'hA000, 8'd40, "R6 live");
    wr(16'h6001, 8'h01);
    tick(1);
    rdChk(16'hA000, 8'd40, "R5 fresh copy");
    wr(16'h7000, 8'h00);
    rdChk(16'hA000, 8'd41, "R5 unlatched");

    // R3 out-of-range select value returns to RAM mode, bank 1
    wr(16'h4000, 8'h0D);
    rdChk(16'hA005, 8'h45, "R3 0x0D");

    // R11 reset
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    rdChk(16'h4000, 8'h81, "R11 rom bank");
    rdChk(16'hA005, 8'hFF, "R11 ram off");
    wr(16'h0000, 8'h0A);
    rdChk(16'hA005, 8'h05, "R11 ram bank");
    selReg(3'd0);
    rdChk(16'hA000, 8'd0, "R11 clock zero");
    tick(1);
    rdChk(16'hA000, 8'd1, "R11 not latched");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule